// File: doc/BRIEF.md
# CEC Interrupt Status Register

This block holds the sticky event flags of a consumer electronics control bus controller and turns them into a single interrupt line. The receive and transmit line engines report events as one-cycle pulses on a 13-bit event vector. Each pulse sets a flag that stays set until software writes 1 to that flag's bit through a plain write-enable, address and data port. A second register selects which flags may drive the interrupt line.

Two flags have extra behaviour. A last-byte event sets both the byte-received flag and the end-of-reception flag. The receive overrun flag is never taken from the event input. It is set when a new byte is stored while the byte-received flag is still pending, and that case also sends a one-cycle stop request to the receiver. Terminal transmit events send a one-cycle request to clear the start-of-message and end-of-message control bits. Arbitration loss does not send that request, so the transmit request stays pending for a retry.

Top module: `cec_irq_status`

## Requirements
- R1: After reset the flag register, the enable register, read data, `irq`, `rx_abort` and `tx_ctl_clr` are all zero.
- R2: An event pulse on `evt_in[i]` sets flag bit i at the clock edge that samples it. Flag positions are: 0 byte received, 1 end of reception, 2 receive overrun, 3 bit rising error, 4 short bit period error, 5 long bit period error, 6 receive missing acknowledge, 7 arbitration lost, 8 transmit byte request, 9 end of transmission, 10 transmit underrun, 11 transmit error, 12 transmit missing acknowledge. `bus_rdata` is registered and shows the register at `bus_addr` one edge after the address is presented (address 0 = flags, address 1 = enable).
- R3: A write to address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: When an event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up 1.
- R5: A pulse on `evt_in[1]` (last byte stored) sets flags 0 and 1 at the same edge.
- R6: If a byte is stored (`evt_in[0]` or `evt_in[1]`) while flag 0 is already 1 before that edge, flag 2 is set and `rx_abort` is 1 for exactly the next cycle. If flag 0 was 0, neither happens.
- R7: A pulse on any of `evt_in[12:9]` makes `tx_ctl_clr` 1 for exactly the next cycle.
- R8: An arbitration-lost pulse (`evt_in[7]`) alone leaves `tx_ctl_clr` at 0.
- R9: `irq` is registered and equals the OR of (flags AND enable) as they stood one edge earlier. A write to address 1 loads the enable register from `bus_wdata[12:0]`.
- R10: Read data bits 31 to 13 are always zero. Writes to those bits change nothing. `evt_in[2]` is ignored, because flag 2 comes only from the overrun rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 13 | One-cycle event pulses from the line engines, one per flag |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 flags, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq | output | 1 | Registered interrupt line |
| rx_abort | output | 1 | One-cycle request to stop reception and withhold acknowledge |
| tx_ctl_clr | output | 1 | One-cycle request to clear the start/end-of-message control bits |

## Verification
Flag state, `rx_abort` and `tx_ctl_clr` change at the edge that samples the event or the write. `bus_rdata` and `irq` follow one edge later. The bench drives inputs on falling edges. It checks the two pulse outputs at the falling edge right after the stimulus edge. It reads flags, enable and `irq` only after one more rising edge, holding the address steady over that edge. Pulse width is also checked at the following falling edge, where both pulse outputs must have dropped again.

// File: rtl/cec_irq_pkg.sv
package cec_irq_pkg;
  localparam int CEC_NFLAGS = 13;
  localparam int F_RXBYTE  = 0;
  localparam int F_RXLAST  = 1;
  localparam int F_RXOVR   = 2;
  localparam int F_ARB     = 7;
  localparam int F_TXDONE  = 9;
  localparam int F_TXUDR   = 10;
  localparam int F_TXERR   = 11;
  localparam int F_TXNACK  = 12;
  localparam logic [1:0] A_FLAGS  = 2'd0;
  localparam logic [1:0] A_ENABLE = 2'd1;
endpackage

// File: rtl/cec_flag_bank.sv
module cec_flag_bank
  import cec_irq_pkg::*;
#(
  parameter int NF = CEC_NFLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] evt,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags,
  output logic          ovr_pulse,
  output logic          txclr_pulse
);
  logic [NF-1:0] set_v;
  logic          byte_stored;
  logic          ovr_hit;
  logic          tx_term;

  assign byte_stored = evt[F_RXBYTE] | evt[F_RXLAST];
  assign ovr_hit     = byte_stored & flags[F_RXBYTE];
  assign tx_term     = evt[F_TXDONE] | evt[F_TXUDR] | evt[F_TXERR] | evt[F_TXNACK];

  always_comb begin
    set_v           = evt;
    set_v[F_RXBYTE] = byte_stored;
    set_v[F_RXOVR]  = ovr_hit;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= set_v[i] | (flags[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_pulse   <= 1'b0;
      txclr_pulse <= 1'b0;
    end else begin
      ovr_pulse   <= ovr_hit;
      txclr_pulse <= tx_term;
    end
  end
endmodule

// File: rtl/cec_irq_mask.sv
module cec_irq_mask #(
  parameter int NF = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_we,
  input  logic [NF-1:0] en_wdata,
  input  logic [NF-1:0] flags,
  output logic [NF-1:0] enable,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_we) enable <= en_wdata;
      irq <= |(flags & enable);
    end
  end
endmodule

// File: rtl/cec_rd_mux.sv
module cec_rd_mux
  import cec_irq_pkg::*;
#(
  parameter int NF     = CEC_NFLAGS,
  parameter int DW     = 32,
  parameter int AW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] enable,
  output logic [DW-1:0] rdata
);
  logic [NF-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == AW'(A_FLAGS))       sel = flags;
    else if (addr == AW'(A_ENABLE)) sel = enable;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(DW-NF){1'b0}}, sel};
  end
endmodule

// File: rtl/cec_irq_status.sv
module cec_irq_status
  import cec_irq_pkg::*;
#(
  parameter int NF = CEC_NFLAGS,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] evt_in,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rx_abort,
  output logic          tx_ctl_clr
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] en_q;
  logic [NF-1:0] clr_mask;
  logic          wr_flags;
  logic          wr_en;

  assign wr_flags = bus_we && (bus_addr == AW'(A_FLAGS));
  assign wr_en    = bus_we && (bus_addr == AW'(A_ENABLE));
  assign clr_mask = wr_flags ? bus_wdata[NF-1:0] : '0;

  cec_flag_bank #(.NF(NF)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt_in),
    .clr         (clr_mask),
    .flags       (flag_q),
    .ovr_pulse   (rx_abort),
    .txclr_pulse (tx_ctl_clr)
  );

  cec_irq_mask #(.NF(NF)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .en_we    (wr_en),
    .en_wdata (bus_wdata[NF-1:0]),
    .flags    (flag_q),
    .enable   (en_q),
    .irq      (irq)
  );

  cec_rd_mux #(.NF(NF), .DW(DW), .AW(AW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .flags  (flag_q),
    .enable (en_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/cec_irq_status_chk.sv
module cec_irq_status_chk #(
  parameter int NF = 13,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [NF-1:0] evt_in,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [NF-1:0] flags,
  input logic          irq,
  input logic          rx_abort,
  input logic          tx_ctl_clr
);
  logic wr0;
  assign wr0 = bus_we && (bus_addr == '0);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (flags == '0 && !irq)); // R1
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst) evt_in[8] |=> flags[8]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr0 && bus_wdata[9] && !evt_in[9]) |=> !flags[9]); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr0 && bus_wdata[4] && evt_in[4]) |=> flags[4]); // R4
  AST_LAST_PAIR: assert property (@(posedge clk) disable iff (rst)
    evt_in[1] |=> (flags[0] && flags[1])); // R5
  AST_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    ((evt_in[0] || evt_in[1]) && flags[0]) |=> (flags[2] && rx_abort)); // R6
  AST_NO_SPURIOUS_ABORT: assert property (@(posedge clk) disable iff (rst)
    !flags[0] |=> !rx_abort); // R6
  AST_TX_CLR: assert property (@(posedge clk) disable iff (rst)
    (|evt_in[12:9]) |=> tx_ctl_clr); // R7
  AST_ARB_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (evt_in[7] && !(|evt_in[12:9])) |=> !tx_ctl_clr); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evt_in == '0 && !wr0) |=> $stable(flags)); // R3
endmodule

bind cec_irq_status cec_irq_status_chk #(.NF(NF), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_in     (evt_in),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .flags      (flag_q),
  .irq        (irq),
  .rx_abort   (rx_abort),
  .tx_ctl_clr (tx_ctl_clr)
);

// File: tb/tb_cec_irq_status.sv
module tb_cec_irq_status;
  localparam int NF = 13;
  logic          clk = 1'b0;
  logic          rst;
  logic [NF-1:0] evt_in;
  logic          bus_we;
  logic [1:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq, rx_abort, tx_ctl_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cec_irq_status dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_abort(rx_abort),
    .tx_ctl_clr(tx_ctl_clr)
  );

  // {event pattern, clear mask, expected flags}
  localparam logic [38:0] VEC [12] = '{
    {13'h0100, 13'h0000, 13'h0100},
    {13'h0008, 13'h0000, 13'h0108},
    {13'h0000, 13'h0100, 13'h0008},
    {13'h0002, 13'h0000, 13'h000B},
    {13'h0001, 13'h0000, 13'h000F},
    {13'h0000, 13'h000F, 13'h0000},
    {13'h1E80, 13'h0000, 13'h1E80},
    {13'h0070, 13'h1E80, 13'h0070},
    {13'h0004, 13'h0000, 13'h0070},
    {13'h0010, 13'h0010, 13'h0070},
    {13'h0000, 13'h1FFF, 13'h0000},
    {13'h0001, 13'h0000, 13'h0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_in = '0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    rst = 1'b1; bus_addr = '0; idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flags", bus_rdata, 32'h0);
    check("R1 irq/pulses", {29'h0, irq, rx_abort, tx_ctl_clr}, 32'h0);
    rd(2'd1, r); check("R1 enable", r, 32'h0);

    // vector walk: R2 R3 R4 R5 R6 R10
    for (int k = 0; k < 12; k++) begin
      evt_in = VEC[k][38:26];
      if (VEC[k][25:13] != '0) begin
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = {19'h0, VEC[k][25:13]};
      end else bus_addr = 2'd0;
      @(negedge clk);
      idle();
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R10 vec%0d", k), bus_rdata, {19'h0, VEC[k][12:0]});
    end

    // R10: writes of upper bits and zeros change nothing
    wr(2'd0, 32'hFFFF_E000);
    rd(2'd0, r); check("R10 upper write ignored", r, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); check("R10 enable upper bits read 0", r, 32'h1FFF);
    wr(2'd1, 32'h0);

    // R6: overrun pulse timing and width (flag 0 is already set)
    evt_in = 13'h0001;
    @(negedge clk); idle();
    check("R6 rx_abort pulse", {31'h0, rx_abort}, 32'h1);
    @(negedge clk);
    check("R6 rx_abort one cycle", {31'h0, rx_abort}, 32'h0);
    wr(2'd0, 32'h1FFF);
    evt_in = 13'h0001;
    @(negedge clk); idle();
    check("R6 no abort when byte flag clear", {31'h0, rx_abort}, 32'h0);

    // R7 / R8
    evt_in = 13'h0400;
    @(negedge clk); idle();
    check("R7 tx_ctl_clr on underrun", {31'h0, tx_ctl_clr}, 32'h1);
    @(negedge clk);
    check("R7 tx_ctl_clr one cycle", {31'h0, tx_ctl_clr}, 32'h0);
    evt_in = 13'h1000;
    @(negedge clk); idle();
    check("R7 tx_ctl_clr on missing ack", {31'h0, tx_ctl_clr}, 32'h1);
    evt_in = 13'h0080;
    @(negedge clk); idle();
    check("R8 arbitration lost keeps control", {31'h0, tx_ctl_clr}, 32'h0);

    // R9: irq masking (flags now 0x1481)
    @(negedge clk);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0002);
    @(negedge clk);
    check("R9 irq unmatched enable", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0080);
    @(negedge clk);
    check("R9 irq asserted", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0080);
    @(negedge clk);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R1: reset from non-zero state
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    rd(2'd0, r); check("R1 flags after re-reset", r, 32'h0);
    rd(2'd1, r); check("R1 enable after re-reset", r, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule